// File: doc/BRIEF.md
# Word-Count DMA Interface Controller

This block joins a host register bus and a 16-bit peripheral through a DMA path that moves one word per handshake. Software writes the two's-complement negative of the number of words into a count register and an even byte address into an address register. Address bits 17:16 sit in the control/status register. A control write that sets the start bit then begins the move. Each moved word adds one to the count and two to the address. When the count reaches zero the block raises its ready flag and, if enabled, pulses an interrupt.

The direction bit picks the flow. Towards the peripheral, the block reads memory and offers the word until the peripheral accepts it. From the peripheral, it takes a word and writes it to memory. Three host function lines are driven from control bits. Three peripheral status lines and an attention line can be read back. A memory access with no acknowledge sets error flags. A maintenance bit aborts a transfer and, once cleared, returns every register to its reset value. After a stop, the residual byte count is twice the negated count register.

Top module: `wcdma_ctrl`

## Requirements
- R1: After reset the control/status register (offset 0) reads 0x0080 (only ready, bit 7, set), the count (offset 1), address (offset 2) and data (offset 3) registers read 0, and irq and mem_req are low.
- R2: A control write without bit 0 drives bits 3:1 onto host_fn, starts nothing and leaves ready set. Status bits 11:9 reflect dev_stat[2:0], and bit 13 reflects dev_attn.
- R3: With ready set, a control write with bit 0 (start) and bit 8 set clears ready and moves words from memory to the peripheral in rising address order. Each word is read at mem_addr and held on out_data with out_valid until out_ack.
- R4: With bit 8 clear, start moves words from the peripheral to memory. A word is taken while in_take and in_valid are both high and is written to mem_addr with mem_we high.
- R5: Each moved word adds 1 to the count and 2 to the 18-bit address. The carry passes into status bits 5:4. When the count reaches zero, ready rises and bus activity stops. Bit 0 of a written address is forced to 0.
- R6: While ready is clear, writes to the count and address registers are ignored, and so are the start, direction and bits 5:4 of control writes.
- R7: A memory access with no mem_ack within TIMEOUT_CYC cycles stops the transfer and sets error (bit 15), non-existent memory (bit 14) and ready. The count keeps the negated number of words not yet moved.
- R8: A control write with bit 15 set clears bits 15 and 14. A write with bit 15 clear leaves them unchanged.
- R9: Writing bit 12 (maintenance) aborts a transfer and sets ready, and the count keeps its residual. A later control write with bit 12 clear returns every register to its reset value.
- R10: With bit 6 (interrupt enable) set, irq pulses high for one cycle after ready rises or after dev_attn rises. With bit 6 clear it stays low.
- R11: The data register (offset 3) reads the last word moved in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 count, 2 address, 3 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| host_fn | output | 3 | Host function lines from control bits 3:1 |
| dev_stat | input | 3 | Peripheral status lines |
| dev_attn | input | 1 | Peripheral attention line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory access done |
| out_data | output | 16 | Word offered to the peripheral |
| out_valid | output | 1 | out_data is valid |
| out_ack | input | 1 | Peripheral accepts out_data |
| in_data | input | 16 | Word from the peripheral |
| in_valid | input | 1 | in_data is valid |
| in_take | output | 1 | Block takes in_data this cycle |
| irq | output | 1 | Interrupt pulse |

## Verification
Moves towards the peripheral use known memory contents, so the order of words and of addresses on the peripheral side can be told apart. A move from the peripheral streams distinct words, so each memory write pairs the correct address with the correct word. A buffer that crosses the 64 KiB boundary shows whether the carry reaches the extended bits. A stalled peripheral, a silent memory and a maintenance abort each leave a known residual count. These cases separate a normal finish from a timeout and from an abort, and show that writes made while busy are dropped.

// File: rtl/wcdma_pkg.sv
package wcdma_pkg;

    localparam int WORD_W = 16;
    localparam int XA_W   = 2;
    localparam int ADDR_W = WORD_W + XA_W;

    localparam int BIT_GO    = 0;
    localparam int BIT_FN_LO = 1;
    localparam int BIT_FN_HI = 3;
    localparam int BIT_XA_LO = 4;
    localparam int BIT_XA_HI = 5;
    localparam int BIT_IE    = 6;
    localparam int BIT_READY = 7;
    localparam int BIT_DIR   = 8;
    localparam int BIT_ST_LO = 9;
    localparam int BIT_ST_HI = 11;
    localparam int BIT_MAINT = 12;
    localparam int BIT_ATTN  = 13;
    localparam int BIT_NEX   = 14;
    localparam int BIT_ERR   = 15;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_ADDR  = 2'd2;
    localparam logic [1:0] SEL_DATA  = 2'd3;

    typedef enum logic [2:0] {
        E_IDLE,
        E_MRD,
        E_PUSH,
        E_PULL,
        E_MWR
    } eng_state_e;

    typedef struct packed {
        logic [2:0]        fn;
        logic              ie;
        logic              dir;
        logic              ready;
        logic              maint;
        logic              nex;
        logic              err;
        logic [WORD_W-1:0] count;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } regs_t;

endpackage

// File: rtl/wcdma_engine.sv
module wcdma_engine
    import wcdma_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_dev,
    input  logic              abort,
    input  logic              last,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              out_ack,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              out_valid,
    output logic              in_take,
    output logic [WORD_W-1:0] word,
    output logic              step,
    output logic              done,
    output logic              nxm
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMR_END = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [TW-1:0]     tmr;
        logic [WORD_W-1:0] word;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d  = e_q;
        step = 1'b0;
        done = 1'b0;
        nxm  = 1'b0;
        case (e_q.st)
            E_IDLE: begin
                if (start) begin
                    e_d.st  = to_dev ? E_MRD : E_PULL;
                    e_d.tmr = '0;
                end
            end
            E_MRD: begin
                if (mem_ack) begin
                    e_d.word = mem_rdata;
                    e_d.st   = E_PUSH;
                end else if (e_q.tmr == TMR_END) begin
                    nxm     = 1'b1;
                    e_d.st  = E_IDLE;
                end else begin
                    e_d.tmr = e_q.tmr + 1'b1;
                end
            end
            E_PUSH: begin
                if (out_ack) begin
                    step = 1'b1;
                    if (last) begin
                        done   = 1'b1;
                        e_d.st = E_IDLE;
                    end else begin
                        e_d.st  = E_MRD;
                        e_d.tmr = '0;
                    end
                end
            end
            E_PULL: begin
                if (in_valid) begin
                    e_d.word = in_data;
                    e_d.st   = E_MWR;
                    e_d.tmr  = '0;
                end
            end
            E_MWR: begin
                if (mem_ack) begin
                    step = 1'b1;
                    if (last) begin
                        done   = 1'b1;
                        e_d.st = E_IDLE;
                    end else begin
                        e_d.st = E_PULL;
                    end
                end else if (e_q.tmr == TMR_END) begin
                    nxm    = 1'b1;
                    e_d.st = E_IDLE;
                end else begin
                    e_d.tmr = e_q.tmr + 1'b1;
                end
            end
            default: e_d.st = E_IDLE;
        endcase
        if (abort) begin
            e_d.st = E_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '{st: E_IDLE, tmr: '0, word: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign mem_req   = (e_q.st == E_MRD) || (e_q.st == E_MWR);
    assign mem_we    = (e_q.st == E_MWR);
    assign out_valid = (e_q.st == E_PUSH);
    assign in_take   = (e_q.st == E_PULL);
    assign word      = e_q.word;

endmodule

// File: rtl/wcdma_irq.sv
module wcdma_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic attn,
    input  logic ie,
    output logic irq
);

    typedef struct packed {
        logic ready_prev;
        logic attn_prev;
        logic irq;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d            = i_q;
        i_d.ready_prev = ready;
        i_d.attn_prev  = attn;
        i_d.irq        = ie && ((ready && !i_q.ready_prev) || (attn && !i_q.attn_prev));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '{ready_prev: 1'b1, attn_prev: 1'b0, irq: 1'b0};
        end else begin
            i_q <= i_d;
        end
    end

    assign irq = i_q.irq;

endmodule

// File: rtl/wcdma_ctrl.sv
module wcdma_ctrl
    import wcdma_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [2:0]        host_fn,
    input  logic [2:0]        dev_stat,
    input  logic              dev_attn,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ack,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_take,
    output logic              irq
);

    regs_t r_d, r_q;

    logic              start, abort;
    logic              step, done, nxm;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] status;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[7], reg_wdata[11:9], reg_wdata[14:13]};

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        abort = 1'b0;

        if (step) begin
            r_d.count = r_q.count + 1'b1;
            r_d.addr  = r_q.addr + ADDR_W'(2);
            r_d.data  = word;
        end
        if (done) begin
            r_d.ready = 1'b1;
        end
        if (nxm) begin
            r_d.ready = 1'b1;
            r_d.err   = 1'b1;
            r_d.nex   = 1'b1;
        end

        if (reg_wr) begin
            case (reg_addr)
                SEL_CTRL: begin
                    if (r_q.maint && !reg_wdata[BIT_MAINT]) begin
                        r_d       = '0;
                        r_d.ready = 1'b1;
                    end else begin
                        r_d.fn = reg_wdata[BIT_FN_HI:BIT_FN_LO];
                        r_d.ie = reg_wdata[BIT_IE];
                        if (reg_wdata[BIT_ERR]) begin
                            r_d.err = 1'b0;
                            r_d.nex = 1'b0;
                        end
                        if (reg_wdata[BIT_MAINT]) begin
                            r_d.maint = 1'b1;
                            r_d.ready = 1'b1;
                            abort     = 1'b1;
                        end else if (r_q.ready) begin
                            r_d.addr[ADDR_W-1:WORD_W] = reg_wdata[BIT_XA_HI:BIT_XA_LO];
                            r_d.dir = reg_wdata[BIT_DIR];
                            if (reg_wdata[BIT_GO]) begin
                                start     = 1'b1;
                                r_d.ready = 1'b0;
                            end
                        end
                    end
                end
                SEL_COUNT: begin
                    if (r_q.ready) r_d.count = reg_wdata;
                end
                SEL_ADDR: begin
                    if (r_q.ready) r_d.addr[WORD_W-1:0] = {reg_wdata[WORD_W-1:1], 1'b0};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ready <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        status                     = '0;
        status[BIT_ERR]            = r_q.err;
        status[BIT_NEX]            = r_q.nex;
        status[BIT_ATTN]           = dev_attn;
        status[BIT_MAINT]          = r_q.maint;
        status[BIT_ST_HI:BIT_ST_LO] = dev_stat;
        status[BIT_DIR]            = r_q.dir;
        status[BIT_READY]          = r_q.ready;
        status[BIT_IE]             = r_q.ie;
        status[BIT_XA_HI:BIT_XA_LO] = r_q.addr[ADDR_W-1:WORD_W];
        status[BIT_FN_HI:BIT_FN_LO] = r_q.fn;
        case (reg_addr)
            SEL_CTRL:  reg_rdata = status;
            SEL_COUNT: reg_rdata = r_q.count;
            SEL_ADDR:  reg_rdata = r_q.addr[WORD_W-1:0];
            default:   reg_rdata = r_q.data;
        endcase
    end

    wcdma_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .to_dev    (r_d.dir),
        .abort     (abort),
        .last      (r_q.count == {WORD_W{1'b1}}),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .out_ack   (out_ack),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .out_valid (out_valid),
        .in_take   (in_take),
        .word      (word),
        .step      (step),
        .done      (done),
        .nxm       (nxm)
    );

    wcdma_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (r_q.ready),
        .attn  (dev_attn),
        .ie    (r_q.ie),
        .irq   (irq)
    );

    assign host_fn   = r_q.fn;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = word;
    assign out_data  = word;

endmodule

// File: rtl/wcdma_ctrl_chk.sv
module wcdma_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [17:0] mem_addr,
    input logic        out_valid,
    input logic        out_ack,
    input logic [15:0] out_data,
    input logic        in_take,
    input logic        ready,
    input logic        ie,
    input logic        err,
    input logic        nex,
    input logic        maint,
    input logic [15:0] count,
    input logic        irq
);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr));

    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> $stable(out_data));

    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || out_valid || in_take) |-> !ready);

    p_nxm_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nex) |-> err && ready);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(maint) |-> ready && !err && (count == 16'h0000));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie));

endmodule

bind wcdma_ctrl wcdma_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .out_data  (out_data),
    .in_take   (in_take),
    .ready     (r_q.ready),
    .ie        (r_q.ie),
    .err       (r_q.err),
    .nex       (r_q.nex),
    .maint     (r_q.maint),
    .count     (r_q.count),
    .irq       (irq)
);

// File: tb/wcdma_ctrl_tb_top.sv
module wcdma_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [2:0]  host_fn;
    logic [2:0]  dev_stat = 3'b000;
    logic        dev_attn = 1'b0;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic        mem_ack = 1'b0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ack = 1'b0;
    logic [15:0] in_data = 16'h0;
    logic        in_valid = 1'b0;
    logic        in_take;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;
    int irq_cnt  = 0;

    bit mem_en = 1'b1;
    bit out_en = 1'b1;

    logic [15:0] mem [int];
    logic [15:0] exp_out [$];
    logic [33:0] exp_wr [$];
    logic [15:0] src [$];
    int          src_idx = 0;
    bit          took = 1'b0;

    always #2 clk = ~clk;

    wcdma_ctrl #(.TIMEOUT_CYC(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_fn(host_fn),
        .dev_stat(dev_stat), .dev_attn(dev_attn), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_data(out_data),
        .out_valid(out_valid), .out_ack(out_ack), .in_data(in_data),
        .in_valid(in_valid), .in_take(in_take), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_ready();
        logic [15:0] s;
        for (int k = 0; k < 500; k++) begin
            rd(2'd0, s);
            if (s[7]) break;
        end
    endtask

    task automatic load_out(input logic [17:0] a, input int n, input logic [15:0] seed, input bit expect_it);
        for (int k = 0; k < n; k++) begin
            mem[int'((a + 18'(2 * k)) >> 1)] = seed + 16'(k * 16'h0111);
            if (expect_it) exp_out.push_back(seed + 16'(k * 16'h0111));
        end
    endtask

    // memory model and write scoreboard monitor
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && mem_en) begin
            if (mem_we) begin
                mem[int'(mem_addr >> 1)] = mem_wdata;
                n_checks++;
                if (exp_wr.size() == 0) begin
                    n_errs++;
                    $display("FAIL R4 unexpected write actual=%h expected=none", {mem_addr, mem_wdata});
                end else begin
                    logic [33:0] e;
                    e = exp_wr.pop_front();
                    if (e !== {mem_addr, mem_wdata}) begin
                        n_errs++;
                        $display("FAIL R4 write actual=%h expected=%h", {mem_addr, mem_wdata}, e);
                    end
                end
            end else begin
                mem_rdata = mem.exists(int'(mem_addr >> 1)) ? mem[int'(mem_addr >> 1)] : 16'hDEAD;
            end
            mem_ack = 1'b1;
        end
    end

    // peripheral sink monitor
    always @(negedge clk) begin
        if (out_ack) begin
            out_ack = 1'b0;
        end else if (out_valid && out_en) begin
            n_checks++;
            if (exp_out.size() == 0) begin
                n_errs++;
                $display("FAIL R3 unexpected word actual=%h expected=none", out_data);
            end else begin
                logic [15:0] e;
                e = exp_out.pop_front();
                if (e !== out_data) begin
                    n_errs++;
                    $display("FAIL R3 word actual=%h expected=%h", out_data, e);
                end
            end
            out_ack = 1'b1;
        end
    end

    // peripheral source driver
    always @(negedge clk) begin
        if (took) src_idx++;
        in_valid = (src_idx < src.size());
        in_data  = in_valid ? src[src_idx] : 16'h0;
        took     = in_valid && in_take;
    end

    always @(negedge clk) if (irq) irq_cnt++;

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int ic;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 16'h0080);
        rd(2'd1, v); chk("R1 count", v, 16'h0);
        rd(2'd2, v); chk("R1 addr", v, 16'h0);
        rd(2'd3, v); chk("R1 data", v, 16'h0);
        chk("R1 irq/mem_req", {irq, mem_req}, 0);

        // R2 function lines settle, status inputs visible, no start
        wr(2'd0, 16'h000E);
        dev_stat = 3'b101; dev_attn = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 host_fn", host_fn, 3'd7);
        chk("R2 mem_req idle", mem_req, 0);
        rd(2'd0, v); chk("R2 status", v, 16'h2A8E);
        dev_stat = 3'b000; dev_attn = 1'b0;
        wr(2'd0, 16'h0000);

        // R3 R5 R11 memory to peripheral, three words
        load_out(18'h00100, 3, 16'hA001, 1'b1);
        wr(2'd1, 16'hFFFD);
        wr(2'd2, 16'h0100);
        wr(2'd0, 16'h0101);
        rd(2'd0, v); chk("R3 ready cleared", v[7], 0);
        wait_ready();
        rd(2'd1, v); chk("R5 count zero", v, 16'h0);
        rd(2'd2, v); chk("R5 addr advanced", v, 16'h0106);
        rd(2'd3, v); chk("R11 last word out", v, 16'hA223);
        chk("R3 all words seen", exp_out.size(), 0);

        // R4 R11 peripheral to memory, four words
        for (int k = 0; k < 4; k++) begin
            src.push_back(16'h5A00 + 16'(k));
            exp_wr.push_back({18'h00200 + 18'(2 * k), 16'h5A00 + 16'(k)});
        end
        wr(2'd1, 16'hFFFC);
        wr(2'd2, 16'h0200);
        wr(2'd0, 16'h0001);
        wait_ready();
        repeat (2) @(negedge clk);
        chk("R4 all writes seen", exp_wr.size(), 0);
        chk("R4 words taken", src_idx, 4);
        rd(2'd2, v); chk("R4 addr advanced", v, 16'h0208);
        rd(2'd3, v); chk("R11 last word in", v, 16'h5A03);

        // R5 carry into extended bits, even address
        load_out(18'h0FFFE, 2, 16'h7700, 1'b1);
        wr(2'd1, 16'hFFFE);
        wr(2'd2, 16'hFFFE);
        wr(2'd0, 16'h0101);
        wait_ready();
        rd(2'd2, v); chk("R5 low addr after carry", v, 16'h0002);
        rd(2'd0, v); chk("R5 extended bits", v[5:4], 2'b01);
        chk("R5 carry words seen", exp_out.size(), 0);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0301);
        rd(2'd2, v); chk("R5 address forced even", v, 16'h0300);

        // R6 writes ignored while busy
        out_en = 1'b0;
        load_out(18'h00400, 2, 16'h3300, 1'b1);
        wr(2'd1, 16'hFFFE);
        wr(2'd2, 16'h0400);
        wr(2'd0, 16'h0101);
        repeat (8) @(negedge clk);
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'h0800);
        wr(2'd0, 16'h0031);
        rd(2'd1, v); chk("R6 count kept", v, 16'hFFFE);
        rd(2'd2, v); chk("R6 addr kept", v, 16'h0400);
        rd(2'd0, v); chk("R6 ctrl fields kept", {v[8], v[7], v[5:4]}, 4'b1000);
        out_en = 1'b1;
        wait_ready();
        rd(2'd1, v); chk("R6 count finished", v, 16'h0);
        rd(2'd2, v); chk("R6 addr finished", v, 16'h0404);

        // R7 memory timeout
        mem_en = 1'b0;
        wr(2'd1, 16'hFFFD);
        wr(2'd2, 16'h0500);
        wr(2'd0, 16'h0101);
        wait_ready();
        rd(2'd0, v); chk("R7 status after timeout", v, 16'hC180);
        rd(2'd1, v); chk("R7 residual count", v, 16'hFFFD);
        chk("R7 bus released", mem_req, 0);
        mem_en = 1'b1;

        // R8 error clearing
        wr(2'd0, 16'h0100);
        rd(2'd0, v); chk("R8 flags kept", v, 16'hC180);
        wr(2'd0, 16'h8000);
        rd(2'd0, v); chk("R8 flags cleared", v, 16'h0080);

        // R9 maintenance abort and release
        out_en = 1'b0;
        load_out(18'h00600, 4, 16'h6100, 1'b0);
        wr(2'd1, 16'hFFFC);
        wr(2'd2, 16'h0600);
        wr(2'd0, 16'h0101);
        repeat (6) @(negedge clk);
        wr(2'd0, 16'h1000);
        rd(2'd0, v); chk("R9 abort status", v, 16'h1180);
        rd(2'd1, v); chk("R9 residual count", v, 16'hFFFC);
        chk("R9 peripheral idle", out_valid, 0);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk("R9 released status", v, 16'h0080);
        rd(2'd1, v); chk("R9 count reset", v, 16'h0);
        rd(2'd3, v); chk("R9 data reset", v, 16'h0);
        out_en = 1'b1;

        // R10 interrupt pulses
        wr(2'd0, 16'h0040);
        ic = irq_cnt;
        @(negedge clk); dev_attn = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 attention pulse", irq_cnt - ic, 1);
        dev_attn = 1'b0;
        load_out(18'h00700, 1, 16'h0F0F, 1'b1);
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h0700);
        ic = irq_cnt;
        wr(2'd0, 16'h0141);
        wait_ready();
        repeat (3) @(negedge clk);
        chk("R10 ready pulse", irq_cnt - ic, 1);
        wr(2'd0, 16'h0000);
        ic = irq_cnt;
        @(negedge clk); dev_attn = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 masked", irq_cnt - ic, 0);
        dev_attn = 1'b0;

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule